// File: doc/BRIEF.md
# Instruction Decoder and Immediate Generator

This block turns one 32-bit instruction word of a small load/store RISC instruction set into the fields and control signals an execution stage needs. It is purely combinational. Decoding is layered: the two top bits give the instruction class. The next level is the six-bit operation code for register and memory classes, or the three-bit format code for the branch/upper-immediate class. The immediate-select bit then picks how operand B is formed.

Beside the controls, it builds every constant the datapath may need: the sign-extended 13-bit immediate, a per-operation operand-B immediate, the upper-immediate value with ten zero low bits, and the byte displacement of a call or a conditional branch. Words that match no supported encoding raise an illegal flag, and all side effects are then held off. The all-ones word is recognised as a halt.

Top module: `instr_decoder`

## Requirements
- R1: A word with bits 31:30 = 01 is a call: `is_call`=1, `reg_we`=1, `rd_idx`=15, `illegal`=0.
- R2: For classes 10 and 11, `rd_idx` = bits 29:25, `op3_code` = bits 24:19, `rs1_idx` = bits 18:14, `imm_sel` = bit 13, `rs2_idx` = bits 4:0.
- R3: `simm_sx` is bits 12:0 sign-extended to 32 bits, for every word.
- R4: In classes 10 and 11, `opb_imm` equals bit 13. `imm_b` is the sign-extended 13-bit field for add, subtract, load, store and jump-and-link. It is the zero-extended 13-bit field for and, or and or-not. It is bits 4:0 zero-extended for shift-right.
- R5: In class 10, op3 selects `alu_op` and `flag_upd`: 010000 add (0, flags), 010001 and (1, flags), 010010 or (2, flags), 010110 or-not (3, flags), 010100 subtract (4, flags), 100110 shift-right (5, no flags). 111000 is jump-and-link: `is_jmpl`=1, add, no flags, writes rd.
- R6: In class 11, op3 000000 is a load (`mem_rd`=1, writes rd, add, no flags). op3 000100 is a store (`mem_wr`=1, `reg_we`=0, add).
- R7: Class 00 with bits 24:22 = 100 is set-high: `is_sethi`=1, writes rd, `alu_op`=6 (pass B), and `sethi_val` = bits 21:0 followed by ten zero bits.
- R8: Class 00 with bits 24:22 = 010 is a branch. `cond_code` = bits 28:25, and `disp_byte` = the sign-extended bits 21:0 times four. Only conditions 0001, 0101, 0110, 0111 and 1000 are legal.
- R9: For a call, `disp_byte` = bits 29:0 times four, modulo 2^32.
- R10: `reg_we` is 0 whenever the destination register index is 0.
- R11: The word 0xFFFFFFFF gives `is_halt`=1, `illegal`=0, and no register write, memory access, flag update or control transfer.
- R12: Any other unmatched encoding gives `illegal`=1. This covers an unlisted op3, a class-00 format code other than 010/100, and an unlisted branch condition. `reg_we`, `mem_rd`, `mem_wr`, `flag_upd`, `is_branch`, `is_jmpl` and `is_sethi` are then all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_in | input | 32 | Instruction word |
| rd_idx | output | 5 | Destination register index (15 for call) |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| op3_code | output | 6 | Raw op3 field |
| imm_sel | output | 1 | Raw immediate-select bit |
| cond_code | output | 4 | Branch condition field |
| reg_we | output | 1 | Register write enable |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| alu_op | output | 3 | ALU operation code |
| opb_imm | output | 1 | Operand B taken from `imm_b` |
| flag_upd | output | 1 | Update condition flags |
| is_branch | output | 1 | Conditional branch |
| is_call | output | 1 | Call |
| is_jmpl | output | 1 | Jump-and-link |
| is_sethi | output | 1 | Set-high |
| is_halt | output | 1 | Halt word |
| illegal | output | 1 | Unsupported encoding |
| simm_sx | output | 32 | Sign-extended 13-bit immediate |
| imm_b | output | 32 | Operand-B immediate, extended per operation |
| sethi_val | output | 32 | Upper-immediate value |
| disp_byte | output | 32 | Call or branch byte displacement |

## Verification
Each class is driven with real encodings: register and immediate forms, positive and negative constants, and all-ones immediates. The all-ones immediates tell sign extension apart from zero extension and from the shift-amount cut. Destination zero is used with a writing operation to separate suppression from normal writes. Neighbouring words are also applied: the halt word against the all-ones-minus-one word, legal against illegal branch conditions, and unlisted op3 and format codes. These show that illegal and halt gating holds back every side effect without masking the legal cases.

// File: rtl/idec_pkg.sv
// Package idec_pkg: field widths, class/ALU codes and opcode constants
// shared by the instruction decoder and its sub-blocks.
package idec_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_W    = 5;
    localparam int OP3_W    = 6;
    localparam int OP2_W    = 3;
    localparam int COND_W   = 4;
    localparam int SIMM_W   = 13;
    localparam int IMM22_W  = 22;
    localparam int DISP30_W = 30;
    localparam int SHAMT_W  = 5;
    localparam int LOWZ_W   = INSTR_W - IMM22_W;

    localparam logic [REG_W-1:0]   LINK_REG  = REG_W'(15);
    localparam logic [INSTR_W-1:0] HALT_WORD = '1;

    typedef enum logic [1:0] {
        CLS_BRSET = 2'b00,
        CLS_CALL  = 2'b01,
        CLS_ALU   = 2'b10,
        CLS_MEM   = 2'b11
    } iclass_e;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_AND   = 3'd1,
        ALU_OR    = 3'd2,
        ALU_ORN   = 3'd3,
        ALU_SUB   = 3'd4,
        ALU_SRL   = 3'd5,
        ALU_PASSB = 3'd6
    } alu_op_e;

    typedef enum logic [1:0] {
        IMMX_SIGN  = 2'd0,
        IMMX_ZERO  = 2'd1,
        IMMX_SHAMT = 2'd2
    } immx_e;

    localparam logic [OP3_W-1:0] OP3_ADDCC = 6'b010000;
    localparam logic [OP3_W-1:0] OP3_ANDCC = 6'b010001;
    localparam logic [OP3_W-1:0] OP3_ORCC  = 6'b010010;
    localparam logic [OP3_W-1:0] OP3_SUBCC = 6'b010100;
    localparam logic [OP3_W-1:0] OP3_ORNCC = 6'b010110;
    localparam logic [OP3_W-1:0] OP3_SRL   = 6'b100110;
    localparam logic [OP3_W-1:0] OP3_JMPL  = 6'b111000;
    localparam logic [OP3_W-1:0] OP3_LD    = 6'b000000;
    localparam logic [OP3_W-1:0] OP3_ST    = 6'b000100;
    localparam logic [OP2_W-1:0] OP2_BR    = 3'b010;
    localparam logic [OP2_W-1:0] OP2_SETHI = 3'b100;

    typedef struct packed {
        iclass_e                cls;
        logic [REG_W-1:0]       rd;
        logic [REG_W-1:0]       rs1;
        logic [REG_W-1:0]       rs2;
        logic [OP3_W-1:0]       op3;
        logic [OP2_W-1:0]       op2;
        logic [COND_W-1:0]      cond;
        logic                   ibit;
        logic [SIMM_W-1:0]      simm;
        logic [IMM22_W-1:0]     imm22;
        logic [DISP30_W-1:0]    disp30;
    } fields_t;
endpackage

// File: rtl/idec_fields.sv
// idec_fields: slices an instruction word into every field any class uses.
// Assumes fixed field positions; overlapping fields are all produced and
// the control decoder picks the ones that apply.
module idec_fields
    import idec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fld
);
    // Purpose: pure bit slicing of the word into named fields.
    always_comb begin
        fld.cls    = iclass_e'(instr[31:30]);
        fld.rd     = instr[29:25];
        fld.op3    = instr[24:19];
        fld.rs1    = instr[18:14];
        fld.ibit   = instr[13];
        fld.rs2    = instr[4:0];
        fld.op2    = instr[24:22];
        fld.cond   = instr[28:25];
        fld.simm   = instr[SIMM_W-1:0];
        fld.imm22  = instr[IMM22_W-1:0];
        fld.disp30 = instr[DISP30_W-1:0];
    end
endmodule

// File: rtl/idec_ctrl.sv
// idec_ctrl: layered control decode (class, then op3/op2, then i bit).
// Produces raw controls before halt/illegal gating and r0 suppression.
// COND_OK is a bit mask of branch conditions accepted as legal.
module idec_ctrl
    import idec_pkg::*;
#(
    parameter logic [15:0] COND_OK = 16'b0000_0001_1110_0010
) (
    input  iclass_e           cls,
    input  logic [OP3_W-1:0]  op3,
    input  logic [OP2_W-1:0]  op2,
    input  logic [COND_W-1:0] cond,
    input  logic              ibit,
    input  logic [REG_W-1:0]  rd,
    output logic [REG_W-1:0]  dst,
    output logic              we_raw,
    output logic              mrd_raw,
    output logic              mwr_raw,
    output alu_op_e           alu,
    output logic              use_imm,
    output logic              flags_raw,
    output logic              br_raw,
    output logic              call_raw,
    output logic              jmpl_raw,
    output logic              sethi_raw,
    output immx_e             immx,
    output logic              bad_raw
);
    // Purpose: map class and sub-opcode to the raw control set.
    always_comb begin
        dst       = rd;
        we_raw    = 1'b0;
        mrd_raw   = 1'b0;
        mwr_raw   = 1'b0;
        alu       = ALU_ADD;
        use_imm   = 1'b0;
        flags_raw = 1'b0;
        br_raw    = 1'b0;
        call_raw  = 1'b0;
        jmpl_raw  = 1'b0;
        sethi_raw = 1'b0;
        immx      = IMMX_SIGN;
        bad_raw   = 1'b0;
        unique case (cls)
            CLS_CALL: begin
                call_raw = 1'b1;
                we_raw   = 1'b1;
                dst      = LINK_REG;
            end
            CLS_ALU: begin
                use_imm = ibit;
                we_raw  = 1'b1;
                case (op3)
                    OP3_ADDCC: begin alu = ALU_ADD; flags_raw = 1'b1; end
                    OP3_SUBCC: begin alu = ALU_SUB; flags_raw = 1'b1; end
                    OP3_ANDCC: begin alu = ALU_AND; flags_raw = 1'b1; immx = IMMX_ZERO; end
                    OP3_ORCC:  begin alu = ALU_OR;  flags_raw = 1'b1; immx = IMMX_ZERO; end
                    OP3_ORNCC: begin alu = ALU_ORN; flags_raw = 1'b1; immx = IMMX_ZERO; end
                    OP3_SRL:   begin alu = ALU_SRL; immx = IMMX_SHAMT; end
                    OP3_JMPL:  begin alu = ALU_ADD; jmpl_raw = 1'b1; end
                    default:   bad_raw = 1'b1;
                endcase
            end
            CLS_MEM: begin
                use_imm = ibit;
                case (op3)
                    OP3_LD:  begin mrd_raw = 1'b1; we_raw = 1'b1; end
                    OP3_ST:  mwr_raw = 1'b1;
                    default: bad_raw = 1'b1;
                endcase
            end
            default: begin
                case (op2)
                    OP2_BR: begin
                        if (COND_OK[cond]) br_raw  = 1'b1;
                        else               bad_raw = 1'b1;
                    end
                    OP2_SETHI: begin
                        sethi_raw = 1'b1;
                        we_raw    = 1'b1;
                        alu       = ALU_PASSB;
                    end
                    default: bad_raw = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/idec_imm.sv
// idec_imm: builds every extended constant from the raw immediate fields.
// disp_call selects the 30-bit call displacement over the 22-bit branch one.
module idec_imm
    import idec_pkg::*;
(
    input  logic [SIMM_W-1:0]   simm,
    input  logic [IMM22_W-1:0]  imm22,
    input  logic [DISP30_W-1:0] disp30,
    input  immx_e               immx,
    input  logic                disp_call,
    output logic [INSTR_W-1:0]  simm_sx,
    output logic [INSTR_W-1:0]  imm_b,
    output logic [INSTR_W-1:0]  sethi_val,
    output logic [INSTR_W-1:0]  disp_byte
);
    localparam int SX_PAD = INSTR_W - SIMM_W;
    localparam int BR_PAD = INSTR_W - IMM22_W - 2;

    // Purpose: sign/zero extension, operand-B variant, upper immediate, displacement.
    always_comb begin
        simm_sx   = {{SX_PAD{simm[SIMM_W-1]}}, simm};
        sethi_val = {imm22, {LOWZ_W{1'b0}}};
        unique case (immx)
            IMMX_ZERO:  imm_b = {{SX_PAD{1'b0}}, simm};
            IMMX_SHAMT: imm_b = {{(INSTR_W-SHAMT_W){1'b0}}, simm[SHAMT_W-1:0]};
            default:    imm_b = simm_sx;
        endcase
        if (disp_call) disp_byte = {disp30, 2'b00};
        else           disp_byte = {{BR_PAD{imm22[IMM22_W-1]}}, imm22, 2'b00};
    end
endmodule

// File: rtl/instr_decoder.sv
// instr_decoder: top of the combinational decoder. Wires fields, control
// decode and immediate generation, then applies halt/illegal gating and
// suppresses writes to register 0. Holds no state.
module instr_decoder
    import idec_pkg::*;
(
    input  logic [31:0] instr_in,
    output logic [4:0]  rd_idx,
    output logic [4:0]  rs1_idx,
    output logic [4:0]  rs2_idx,
    output logic [5:0]  op3_code,
    output logic        imm_sel,
    output logic [3:0]  cond_code,
    output logic        reg_we,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [2:0]  alu_op,
    output logic        opb_imm,
    output logic        flag_upd,
    output logic        is_branch,
    output logic        is_call,
    output logic        is_jmpl,
    output logic        is_sethi,
    output logic        is_halt,
    output logic        illegal,
    output logic [31:0] simm_sx,
    output logic [31:0] imm_b,
    output logic [31:0] sethi_val,
    output logic [31:0] disp_byte
);
    fields_t          fld;
    logic [REG_W-1:0] dst;
    logic             we_raw, mrd_raw, mwr_raw, use_imm, flags_raw;
    logic             br_raw, call_raw, jmpl_raw, sethi_raw, bad_raw;
    alu_op_e          alu;
    immx_e            immx;
    logic             quiet;

    idec_fields u_fields (.instr(instr_in), .fld(fld));

    idec_ctrl u_ctrl (
        .cls(fld.cls), .op3(fld.op3), .op2(fld.op2), .cond(fld.cond),
        .ibit(fld.ibit), .rd(fld.rd), .dst(dst), .we_raw(we_raw),
        .mrd_raw(mrd_raw), .mwr_raw(mwr_raw), .alu(alu), .use_imm(use_imm),
        .flags_raw(flags_raw), .br_raw(br_raw), .call_raw(call_raw),
        .jmpl_raw(jmpl_raw), .sethi_raw(sethi_raw), .immx(immx), .bad_raw(bad_raw)
    );

    idec_imm u_imm (
        .simm(fld.simm), .imm22(fld.imm22), .disp30(fld.disp30), .immx(immx),
        .disp_call(call_raw), .simm_sx(simm_sx), .imm_b(imm_b),
        .sethi_val(sethi_val), .disp_byte(disp_byte)
    );

    // Purpose: halt detection, side-effect gating and r0 write suppression.
    always_comb begin
        is_halt   = (instr_in == HALT_WORD);
        quiet     = bad_raw | is_halt;
        illegal   = bad_raw & ~is_halt;
        rd_idx    = dst;
        rs1_idx   = fld.rs1;
        rs2_idx   = fld.rs2;
        op3_code  = fld.op3;
        imm_sel   = fld.ibit;
        cond_code = fld.cond;
        alu_op    = alu;
        opb_imm   = use_imm & ~quiet;
        reg_we    = we_raw & ~quiet & (dst != '0);
        mem_rd    = mrd_raw & ~quiet;
        mem_wr    = mwr_raw & ~quiet;
        flag_upd  = flags_raw & ~quiet;
        is_branch = br_raw & ~quiet;
        is_call   = call_raw & ~quiet;
        is_jmpl   = jmpl_raw & ~quiet;
        is_sethi  = sethi_raw & ~quiet;
    end
endmodule

// File: rtl/instr_decoder_chk.sv
// instr_decoder_chk: property checker for instr_decoder, bound below.
// The block is combinational, so checks are immediate assertions
// evaluated whenever the decoder's inputs or outputs change.
module instr_decoder_chk (
    input logic [31:0] instr_in,
    input logic [4:0]  rd_idx,
    input logic        reg_we,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        flag_upd,
    input logic        is_branch,
    input logic        is_call,
    input logic        is_jmpl,
    input logic        is_sethi,
    input logic        is_halt,
    input logic        illegal,
    input logic [31:0] simm_sx,
    input logic [31:0] sethi_val
);
    // Purpose: relate decoder inputs and outputs on every change.
    always_comb begin
        AST_CALL_LINK: assert (!is_call || (reg_we && rd_idx == 5'd15)); // R1
        AST_SX_UPPER: assert (simm_sx[31:12] == {20{instr_in[12]}}); // R3
        AST_ONE_KIND: assert ($onehot0({mem_rd, mem_wr, is_branch, is_call, is_jmpl, is_sethi})); // R6
        AST_SETHI_LOW: assert (!is_sethi || sethi_val[9:0] == 10'd0); // R7
        AST_NO_R0_WRITE: assert (!reg_we || rd_idx != 5'd0); // R10
        AST_HALT_QUIET: assert (!is_halt || !(illegal || reg_we || mem_rd || mem_wr || flag_upd || is_branch || is_jmpl)); // R11
        AST_ILLEGAL_QUIET: assert (!illegal || !(reg_we || mem_rd || mem_wr || flag_upd || is_branch || is_jmpl || is_sethi)); // R12
    end
endmodule

bind instr_decoder instr_decoder_chk chk_i (
    .instr_in(instr_in), .rd_idx(rd_idx), .reg_we(reg_we), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .flag_upd(flag_upd), .is_branch(is_branch),
    .is_call(is_call), .is_jmpl(is_jmpl), .is_sethi(is_sethi),
    .is_halt(is_halt), .illegal(illegal), .simm_sx(simm_sx),
    .sethi_val(sethi_val)
);

// File: tb/instr_decoder_tb_top.sv
// instr_decoder_tb_top: directed bench, one task per scenario.
module instr_decoder_tb_top;
    logic        clk = 1'b0;
    logic [31:0] instr_in;
    logic [4:0]  rd_idx, rs1_idx, rs2_idx;
    logic [5:0]  op3_code;
    logic        imm_sel;
    logic [3:0]  cond_code;
    logic        reg_we, mem_rd, mem_wr, opb_imm, flag_upd;
    logic [2:0]  alu_op;
    logic        is_branch, is_call, is_jmpl, is_sethi, is_halt, illegal;
    logic [31:0] simm_sx, imm_b, sethi_val, disp_byte;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    instr_decoder dut_i (
        .instr_in(instr_in), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .op3_code(op3_code), .imm_sel(imm_sel), .cond_code(cond_code),
        .reg_we(reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_op(alu_op),
        .opb_imm(opb_imm), .flag_upd(flag_upd), .is_branch(is_branch),
        .is_call(is_call), .is_jmpl(is_jmpl), .is_sethi(is_sethi),
        .is_halt(is_halt), .illegal(illegal), .simm_sx(simm_sx), .imm_b(imm_b),
        .sethi_val(sethi_val), .disp_byte(disp_byte)
    );

    function automatic logic [31:0] f3(input logic [1:0] op, input logic [4:0] rd,
                                       input logic [5:0] op3, input logic [4:0] rs1,
                                       input logic ib, input logic [12:0] low);
        return {op, rd, op3, rs1, ib, low};
    endfunction

    function automatic logic [31:0] fbr(input logic [3:0] cnd, input logic [21:0] d);
        return {2'b00, 1'b0, cnd, 3'b010, d};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, sample one ns later (combinational path).
    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr_in = w;
        #1;
    endtask

    task automatic t_zero_word();
        apply(32'h0000_0000);
        chk("R12", "zero illegal", {31'd0, illegal}, 32'd1);
        chk("R12", "zero reg_we", {31'd0, reg_we}, 32'd0);
    endtask

    task automatic t_call();
        apply({2'b01, 30'd10});
        chk("R1", "call flag", {31'd0, is_call}, 32'd1);
        chk("R1", "call we", {31'd0, reg_we}, 32'd1);
        chk("R1", "call rd", {27'd0, rd_idx}, 32'd15);
        chk("R1", "call legal", {31'd0, illegal}, 32'd0);
        chk("R9", "call disp +10", disp_byte, 32'd40);
        apply({2'b01, 30'h3FFF_FFFF});
        chk("R9", "call disp -1", disp_byte, 32'hFFFF_FFFC);
    endtask

    task automatic t_alu();
        apply(f3(2'b10, 5'd7, 6'b010000, 5'd5, 1'b0, 13'd6));
        chk("R2", "rd", {27'd0, rd_idx}, 32'd7);
        chk("R2", "rs1", {27'd0, rs1_idx}, 32'd5);
        chk("R2", "rs2", {27'd0, rs2_idx}, 32'd6);
        chk("R2", "op3", {26'd0, op3_code}, 32'h10);
        chk("R2", "ibit", {31'd0, imm_sel}, 32'd0);
        chk("R5", "add op", {29'd0, alu_op}, 32'd0);
        chk("R5", "add flags", {31'd0, flag_upd}, 32'd1);
        chk("R4", "reg form", {31'd0, opb_imm}, 32'd0);
        apply(f3(2'b10, 5'd7, 6'b010000, 5'd5, 1'b1, 13'h1FFF));
        chk("R3", "simm -1", simm_sx, 32'hFFFF_FFFF);
        chk("R4", "add imm sx", imm_b, 32'hFFFF_FFFF);
        chk("R4", "imm form", {31'd0, opb_imm}, 32'd1);
        apply(f3(2'b10, 5'd2, 6'b010001, 5'd1, 1'b1, 13'h1FFF));
        chk("R5", "and op", {29'd0, alu_op}, 32'd1);
        chk("R4", "and imm zx", imm_b, 32'h0000_1FFF);
        chk("R3", "simm sx on and", simm_sx, 32'hFFFF_FFFF);
        apply(f3(2'b10, 5'd2, 6'b010010, 5'd1, 1'b0, 13'd3));
        chk("R5", "or op", {29'd0, alu_op}, 32'd2);
        apply(f3(2'b10, 5'd2, 6'b010110, 5'd1, 1'b1, 13'h0FF0));
        chk("R5", "orn op", {29'd0, alu_op}, 32'd3);
        chk("R3", "simm positive", simm_sx, 32'h0000_0FF0);
        apply(f3(2'b10, 5'd3, 6'b010100, 5'd1, 1'b0, 13'd2));
        chk("R5", "sub op", {29'd0, alu_op}, 32'd4);
        chk("R5", "sub flags", {31'd0, flag_upd}, 32'd1);
        apply(f3(2'b10, 5'd1, 6'b100110, 5'd1, 1'b1, 13'h1FEA));
        chk("R5", "srl op", {29'd0, alu_op}, 32'd5);
        chk("R5", "srl no flags", {31'd0, flag_upd}, 32'd0);
        chk("R4", "srl shamt", imm_b, 32'd10);
    endtask

    task automatic t_mem();
        apply(f3(2'b11, 5'd4, 6'b000000, 5'd1, 1'b1, 13'd12));
        chk("R6", "ld mem_rd", {31'd0, mem_rd}, 32'd1);
        chk("R6", "ld we", {31'd0, reg_we}, 32'd1);
        chk("R6", "ld no flags", {31'd0, flag_upd}, 32'd0);
        chk("R2", "ld rd", {27'd0, rd_idx}, 32'd4);
        chk("R4", "ld imm", imm_b, 32'd12);
        apply(f3(2'b11, 5'd5, 6'b000100, 5'd2, 1'b1, 13'h1FF1));
        chk("R6", "st mem_wr", {31'd0, mem_wr}, 32'd1);
        chk("R6", "st no we", {31'd0, reg_we}, 32'd0);
        chk("R6", "st no rd", {31'd0, mem_rd}, 32'd0);
        chk("R6", "st add", {29'd0, alu_op}, 32'd0);
        chk("R4", "st imm neg", imm_b, 32'hFFFF_FFF1);
    endtask

    task automatic t_jmpl();
        apply(f3(2'b10, 5'd0, 6'b111000, 5'd15, 1'b1, 13'd4));
        chk("R5", "jmpl flag", {31'd0, is_jmpl}, 32'd1);
        chk("R10", "jmpl r0 no we", {31'd0, reg_we}, 32'd0);
        chk("R4", "jmpl imm", imm_b, 32'd4);
        chk("R5", "jmpl no flags", {31'd0, flag_upd}, 32'd0);
        apply(f3(2'b10, 5'd3, 6'b111000, 5'd15, 1'b0, 13'd2));
        chk("R5", "jmpl we", {31'd0, reg_we}, 32'd1);
    endtask

    task automatic t_r0();
        apply(f3(2'b10, 5'd0, 6'b010000, 5'd1, 1'b0, 13'd2));
        chk("R10", "add to r0 we", {31'd0, reg_we}, 32'd0);
        chk("R10", "add to r0 flags", {31'd0, flag_upd}, 32'd1);
        apply({2'b00, 5'd0, 3'b100, 22'h1});
        chk("R10", "sethi r0 we", {31'd0, reg_we}, 32'd0);
    endtask

    task automatic t_sethi();
        apply({2'b00, 5'd1, 3'b100, 22'h2AF366});
        chk("R7", "sethi val", sethi_val, 32'hABCD_9800);
        chk("R7", "sethi flag", {31'd0, is_sethi}, 32'd1);
        chk("R7", "sethi we", {31'd0, reg_we}, 32'd1);
        chk("R7", "sethi op", {29'd0, alu_op}, 32'd6);
    endtask

    task automatic t_branch();
        apply(fbr(4'b0001, 22'h3FFFFE));
        chk("R8", "be flag", {31'd0, is_branch}, 32'd1);
        chk("R8", "be cond", {28'd0, cond_code}, 32'd1);
        chk("R8", "be disp -2", disp_byte, 32'hFFFF_FFF8);
        chk("R8", "be no we", {31'd0, reg_we}, 32'd0);
        apply(fbr(4'b1000, 22'd3));
        chk("R8", "ba disp", disp_byte, 32'd12);
        chk("R8", "ba legal", {31'd0, illegal}, 32'd0);
        apply(fbr(4'b0010, 22'd3));
        chk("R12", "bad cond illegal", {31'd0, illegal}, 32'd1);
        chk("R12", "bad cond no branch", {31'd0, is_branch}, 32'd0);
    endtask

    task automatic t_halt();
        apply(32'hFFFF_FFFF);
        chk("R11", "halt flag", {31'd0, is_halt}, 32'd1);
        chk("R11", "halt legal", {31'd0, illegal}, 32'd0);
        chk("R11", "halt no we", {31'd0, reg_we}, 32'd0);
        chk("R11", "halt no mem", {30'd0, mem_rd, mem_wr}, 32'd0);
        apply(32'hFFFF_FFFE);
        chk("R11", "near halt", {31'd0, is_halt}, 32'd0);
        chk("R12", "near halt illegal", {31'd0, illegal}, 32'd1);
    endtask

    task automatic t_illegal();
        apply(f3(2'b10, 5'd3, 6'b000001, 5'd1, 1'b0, 13'd2));
        chk("R12", "alu op3 illegal", {31'd0, illegal}, 32'd1);
        chk("R12", "alu op3 no we", {31'd0, reg_we}, 32'd0);
        chk("R12", "alu op3 no flags", {31'd0, flag_upd}, 32'd0);
        apply(f3(2'b11, 5'd3, 6'b111000, 5'd1, 1'b0, 13'd2));
        chk("R12", "mem op3 illegal", {31'd0, illegal}, 32'd1);
        chk("R12", "mem op3 quiet", {30'd0, mem_rd, mem_wr}, 32'd0);
        apply({2'b00, 5'd4, 3'b011, 22'h5});
        chk("R12", "op2 illegal", {31'd0, illegal}, 32'd1);
        chk("R12", "op2 quiet", {30'd0, is_sethi, reg_we}, 32'd0);
    endtask

    initial begin
        instr_in = '0;
        t_zero_word();
        t_call();
        t_alu();
        t_mem();
        t_jmpl();
        t_r0();
        t_sethi();
        t_branch();
        t_halt();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule